// File: doc/BRIEF.md
# Packed Rounding Shift and Narrow Unit

This combinational unit right-shifts packed lanes of a 32-bit operand. The mode select picks one of three lane layouts:

- Four signed bytes, each shifted arithmetically, with optional rounding.
- Two unsigned halfwords, each shifted logically.
- A narrowing layout. Here one signed word from each of two operands is shifted arithmetically and optionally rounded. The low 16 bits of each shifted word are then packed into one halfword of the result.

Rounding adds the last bit that the shift discarded back into the shifted lane. Because of this, a shift amount of zero never rounds. The unit sits in an execute stage and receives its operands and amount from decode logic that is outside this block.

Top module: `packed_rshift_narrow`

## Requirements
- R1: With mode 2'b00, each byte lane of opA (lane i at bits 8i+7:8i) is shifted arithmetically right by shAmt[2:0]. The vacated bits take the lane sign. shAmt[4:3] and opB have no effect.
- R2: In byte mode and narrow mode, when roundEn is 1 and the effective amount k is nonzero, the shifted lane is incremented by one if bit k-1 of the original lane is 1.
- R3: An effective amount of zero passes each lane through unchanged, whatever the value of roundEn.
- R4: A rounded lane wraps within its own width, so carries never cross into a neighbouring lane.
- R5: With mode 2'b01, each 16-bit lane of opA (lane 0 at bits 15:0) is shifted logically right by shAmt[3:0] and filled with zeros. roundEn, shAmt[4] and opB have no effect.
- R6: With mode 2'b10, opA is taken as a signed word and shifted arithmetically by shAmt[4:0], with the rule of R2. The result goes to result[31:16]. opB is treated the same way, and its result goes to result[15:0].
- R7: In narrow mode, each shifted word is truncated to its low 16 bits. Upper bits are dropped with no saturation.
- R8: Mode 2'b11 drives result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand: the byte or halfword lanes, or the upper narrow word |
| opB | input | 32 | Second operand: the lower narrow word |
| shAmt | input | 5 | Shift amount; the mode decides how many low bits are used |
| mode | input | 2 | 00 byte arithmetic, 01 halfword logical, 10 narrow, 11 idle |
| roundEn | input | 1 | Enables rounding in byte and narrow modes |
| result | output | 32 | Packed shifted result |

## Verification
The immediate assertions are evaluated whenever the inputs change. They check four things:
- A zero-amount lane passes through unchanged.
- An unrounded arithmetic lane keeps its sign.
- A logical lane never grows.
- The lane-select strobes are at most one-hot, and the idle mode gives zero.

The exact rounding values, the wrap of a rounded lane, the narrow truncation and the placement of each lane can only be shown by the bench. It compares results against an independent model over every shift amount, using edge-value lanes and random lanes.

// File: rtl/prsn_pkg.sv
package prsn_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;
  localparam int AMT_W  = 5;
  localparam int N_BYTE = WORD_W / BYTE_W;
  localparam int N_HALF = WORD_W / HALF_W;
  localparam int BYTE_AMT_W = $clog2(BYTE_W);
  localparam int HALF_AMT_W = $clog2(HALF_W);
  localparam int WORD_AMT_W = $clog2(WORD_W);

  typedef enum logic [1:0] {
    MODE_BYTE   = 2'b00,
    MODE_HALF   = 2'b01,
    MODE_NARROW = 2'b10,
    MODE_IDLE   = 2'b11
  } shMode_e;

  typedef struct packed {
    logic byteSel;
    logic halfSel;
    logic narrowSel;
    logic roundOn;
  } shCtrl_t;
endpackage

// File: rtl/prsn_lane.sv
module prsn_lane #(
  parameter int W = 8,
  parameter int AW = 3,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          roundIn,
  output logic [W-1:0]  dout
);
  logic [W-1:0]  shifted;
  logic [AW-1:0] lastIdx;
  logic          lostBit;

  generate
    if (IS_SIGNED) begin : g_arith
      assign shifted = $unsigned($signed(din) >>> amt);
    end else begin : g_logic
      assign shifted = din >> amt;
    end
  endgenerate

  assign lastIdx = amt - {{(AW-1){1'b0}}, 1'b1};
  assign lostBit = (amt != '0) ? din[lastIdx] : 1'b0;
  // wraps within W bits by construction of the adder width (R4)
  assign dout = shifted + {{(W-1){1'b0}}, (roundIn & lostBit)};

  always_comb begin
    // R3
    if (amt == '0) begin
      zero_amt_chk: assert (dout == din);
    end
    // R1
    if (IS_SIGNED && !roundIn) begin
      sign_keep_chk: assert (dout[W-1] == din[W-1]);
    end
    // R5
    if (!IS_SIGNED && !roundIn) begin
      no_growth_chk: assert (dout <= din);
    end
  end
endmodule

// File: rtl/prsn_ctrl.sv
module prsn_ctrl
  import prsn_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       roundEn,
  output shCtrl_t    ctrl
);
  shMode_e modeSel;
  assign modeSel = shMode_e'(mode);

  always_comb begin
    ctrl = '0;
    unique case (modeSel)
      MODE_BYTE:   ctrl.byteSel   = 1'b1;
      MODE_HALF:   ctrl.halfSel   = 1'b1;
      MODE_NARROW: ctrl.narrowSel = 1'b1;
      default:     ctrl = '0;
    endcase
    // halfword lanes never round (R5)
    ctrl.roundOn = roundEn & (ctrl.byteSel | ctrl.narrowSel);
  end

  always_comb begin
    // R8
    sel_onehot_chk: assert ($onehot0({ctrl.byteSel, ctrl.halfSel, ctrl.narrowSel}));
  end
endmodule

// File: rtl/prsn_datapath.sv
module prsn_datapath
  import prsn_pkg::*;
(
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [AMT_W-1:0]  shAmt,
  input  shCtrl_t           ctrl,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] byteRes;
  logic [WORD_W-1:0] halfRes;
  logic [WORD_W-1:0] wordARes;
  logic [WORD_W-1:0] wordBRes;
  logic [WORD_W-1:0] narrowRes;

  genvar gi;
  generate
    for (gi = 0; gi < N_BYTE; gi++) begin : g_byte
      prsn_lane #(.W(BYTE_W), .AW(BYTE_AMT_W), .IS_SIGNED(1'b1)) u_lane (
        .din    (opA[gi*BYTE_W +: BYTE_W]),
        .amt    (shAmt[BYTE_AMT_W-1:0]),
        .roundIn(ctrl.roundOn),
        .dout   (byteRes[gi*BYTE_W +: BYTE_W])
      );
    end
    for (gi = 0; gi < N_HALF; gi++) begin : g_half
      prsn_lane #(.W(HALF_W), .AW(HALF_AMT_W), .IS_SIGNED(1'b0)) u_lane (
        .din    (opA[gi*HALF_W +: HALF_W]),
        .amt    (shAmt[HALF_AMT_W-1:0]),
        .roundIn(1'b0),
        .dout   (halfRes[gi*HALF_W +: HALF_W])
      );
    end
  endgenerate

  prsn_lane #(.W(WORD_W), .AW(WORD_AMT_W), .IS_SIGNED(1'b1)) u_wordA (
    .din(opA), .amt(shAmt[WORD_AMT_W-1:0]), .roundIn(ctrl.roundOn), .dout(wordARes)
  );
  prsn_lane #(.W(WORD_W), .AW(WORD_AMT_W), .IS_SIGNED(1'b1)) u_wordB (
    .din(opB), .amt(shAmt[WORD_AMT_W-1:0]), .roundIn(ctrl.roundOn), .dout(wordBRes)
  );

  // low halves only: upper bits are dropped (R7)
  assign narrowRes = {wordARes[HALF_W-1:0], wordBRes[HALF_W-1:0]};

  always_comb begin
    result = '0;
    if (ctrl.byteSel)   result = byteRes;
    if (ctrl.halfSel)   result = halfRes;
    if (ctrl.narrowSel) result = narrowRes;
  end
endmodule

// File: rtl/packed_rshift_narrow.sv
module packed_rshift_narrow
  import prsn_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [4:0]  shAmt,
  input  logic [1:0]  mode,
  input  logic        roundEn,
  output logic [31:0] result
);
  shCtrl_t ctrl;

  prsn_ctrl u_ctrl (
    .mode   (mode),
    .roundEn(roundEn),
    .ctrl   (ctrl)
  );

  prsn_datapath u_dp (
    .opA   (opA),
    .opB   (opB),
    .shAmt (shAmt),
    .ctrl  (ctrl),
    .result(result)
  );

  always_comb begin
    // R8
    if (mode == 2'b11) begin
      idle_zero_chk: assert (result == 32'h0);
    end
  end
endmodule

// File: tb/packed_rshift_narrow_tb.sv
module packed_rshift_narrow_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] opA = '0, opB = '0;
  logic [4:0]  shAmt = '0;
  logic [1:0]  mode = 2'b11;
  logic        roundEn = 1'b0;
  logic [31:0] result;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  packed_rshift_narrow u_dut (
    .opA(opA), .opB(opB), .shAmt(shAmt), .mode(mode), .roundEn(roundEn), .result(result)
  );

  function automatic logic [31:0] refModel(input logic [31:0] a, input logic [31:0] b,
                                           input int k, input int md, input bit rnd);
    logic [31:0] r;
    longint v;
    longint q;
    int s;
    r = '0;
    case (md)
      0: begin
        s = k & 7;
        for (int i = 0; i < 4; i++) begin
          v = longint'($signed(a[8*i +: 8]));
          q = v >>> s;
          if (rnd && s != 0 && a[8*i + s - 1]) q = q + 1;
          r[8*i +: 8] = q[7:0];
        end
      end
      1: begin
        s = k & 15;
        for (int i = 0; i < 2; i++) r[16*i +: 16] = a[16*i +: 16] >> s;
      end
      2: begin
        s = k & 31;
        v = longint'($signed(a));
        q = v >>> s;
        if (rnd && s != 0 && a[s-1]) q = q + 1;
        r[31:16] = q[15:0];
        v = longint'($signed(b));
        q = v >>> s;
        if (rnd && s != 0 && b[s-1]) q = q + 1;
        r[15:0] = q[15:0];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input int k,
                       input int md, input bit rnd);
    @(negedge clk);
    opA = a; opB = b; shAmt = k[4:0]; mode = md[1:0]; roundEn = rnd;
    #2;
  endtask

  task automatic applyRef(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input int k, input int md, input bit rnd);
    drive(a, b, k, md, rnd);
    check(tag, result, refModel(a, b, k, md, rnd));
  endtask

  task automatic testIdleStart();
    #2;
    check("R8 idle at start", result, 32'h0);
    applyRef("R8 idle ignores inputs", 32'hFFFF_FFFF, 32'h1234_5678, 31, 3, 1'b1);
  endtask

  task automatic testByteSweep();
    logic [31:0] edges [6] = '{32'h807F_FF00, 32'h7F80_0180, 32'hFFFF_FFFF,
                               32'h5AA5_C33C, 32'h0102_0408, 32'h81FE_7E01};
    for (int e = 0; e < 6; e++)
      for (int k = 0; k < 32; k++)
        for (int r = 0; r < 2; r++)
          applyRef("R1 R2 byte sweep", edges[e], 32'hDEAD_BEEF, k, 0, r[0]);
    for (int n = 0; n < 200; n++)
      applyRef("R1 R2 byte random", $urandom, $urandom, $urandom % 32, 0, n[0]);
  endtask

  task automatic testHalfSweep();
    for (int k = 0; k < 32; k++)
      for (int r = 0; r < 2; r++)
        applyRef("R5 half sweep", 32'h8000_FFFF, 32'h1111_2222, k, 1, r[0]);
    for (int n = 0; n < 200; n++)
      applyRef("R5 half random", $urandom, $urandom, $urandom % 32, 1, n[0]);
  endtask

  task automatic testNarrowSweep();
    for (int k = 0; k < 32; k++)
      for (int r = 0; r < 2; r++) begin
        applyRef("R6 narrow sweep", 32'h8000_0001, 32'h7FFF_FFFF, k, 2, r[0]);
        applyRef("R6 narrow sweep alt", 32'hAAAA_5555, 32'hFFFF_FFFF, k, 2, r[0]);
      end
    for (int n = 0; n < 200; n++)
      applyRef("R6 narrow random", $urandom, $urandom, $urandom % 32, 2, n[0]);
  endtask

  task automatic testDirected();
    // lanes 04,7F,FF,80 shifted by 1 with rounding; FF wraps to 00
    drive(32'h80FF_7F04, 32'h0, 1, 0, 1'b1);
    check("R2 R4 byte round wrap", result, 32'hC000_4002);
    drive(32'h80FF_7F04, 32'h0, 0, 0, 1'b1);
    check("R3 byte zero amount", result, 32'h80FF_7F04);
    drive(32'h8080_8080, 32'h0, 5'b11111, 0, 1'b0);
    check("R1 byte upper amount bits ignored", result, 32'hFFFF_FFFF);
    drive(32'h8000_FFFF, 32'h0, 5'b11111, 1, 1'b1);
    check("R5 half logical fill", result, 32'h0001_0001);
    drive(32'h7FFF_FFFF, 32'h8000_0000, 0, 2, 1'b1);
    check("R7 narrow truncation", result, 32'hFFFF_0000);
    drive(32'h0003_0000, 32'hFFFF_FFFF, 1, 2, 1'b1);
    check("R6 narrow halves", result, 32'h8000_0000);
  endtask

  task automatic testOpBIgnored();
    drive(32'h1234_8765, 32'h0000_0000, 3, 0, 1'b1);
    check("R1 byte opB ignored a", result, refModel(32'h1234_8765, 32'h0, 3, 0, 1'b1));
    drive(32'h1234_8765, 32'hFFFF_FFFF, 3, 0, 1'b1);
    check("R1 byte opB ignored b", result, refModel(32'h1234_8765, 32'h0, 3, 0, 1'b1));
    drive(32'h1234_8765, 32'hFFFF_FFFF, 7, 1, 1'b1);
    check("R5 half opB and round ignored", result, 32'h0024_010E);
  endtask

  initial begin
    testIdleStart();
    testDirected();
    testOpBIgnored();
    testByteSweep();
    testHalfSweep();
    testNarrowSweep();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule